// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This controller sits on the host side of a 24-bit delta-sigma converter that has a serial port with a select line, a serial clock, a data line into the converter and a data line out of it. A `start` request pulls select low. The controller then polls the converter's data-out line, which shows the end-of-conversion level. When that level goes low, the controller runs one 32-clock full-duplex frame. During the frame it reads the 32-bit output word and, on the same clocks, sends the 13-bit channel and configuration word for the next conversion.

When the frame ends, the controller releases select. It decodes the two status bits into sign, overrange and underrange flags and checks the dummy bit for a framing error. It presents the 24-bit result and the five sub-LSB bits with a one-cycle valid strobe. Clamped out-of-range codes pass through unchanged, and the matching flag is set. If the converter never reports ready within a programmable number of cycles, the controller gives up, pulses a timeout flag and releases select. The serial-clock rate is set by a divider input.

Top module: `sdadc_readout`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `sdi` is 0, and `valid` and `timeout` are 0. The configuration register holds 13'h1410, which is the bit sequence 1,0,1,0,0,0,0,0,1,0,0,0,0. This selects the channel 0/1 pair, combined line rejection and 1x rate. A frame that runs with no prior `cfg_wr` sends this value.
- R2: A `start` pulse while the controller is idle drives `cs_n` low. No rising edge of `sck` occurs until `sdo` has been seen low while `cs_n` is low.
- R3: If `sdo` stays high, `timeout` pulses for one cycle on the (`tmo_limit`+1)th clock edge after the edge that lowered `cs_n`. `cs_n` returns to 1 on that same edge, and no `valid` follows.
- R4: A frame has exactly 32 `sck` pulses. Each high phase and each low phase lasts `sck_div`+1 clock cycles, and `sck` is 0 whenever `cs_n` is 1.
- R5: `sdo` is sampled at each rising `sck` edge, giving word bits 31 down to 0. `result` equals bits 28..5, with bit 28 as the MSB, and `sub_lsb` equals bits 4..0.
- R6: On `sdi` the frame carries the 13-bit configuration word, MSB first, one bit per rising `sck` edge. `sdi` changes only while `sck` is low. It reads 0 for the remaining 19 rising edges.
- R7: `sign` equals bit 29. `ovr` is set when bits 29 and 28 are both 1. `unr` is set when both are 0. Both flags are clear for the other two combinations.
- R8: `frame_err` equals bit 30, which is the dummy bit and should read 0.
- R9: `valid` pulses for exactly one cycle, on the edge where the 32nd falling `sck` edge occurs and `cs_n` returns to 1. `result`, `sub_lsb` and the flags hold their values until the next completed frame.
- R10: A `start` pulse during a frame is ignored. A `cfg_wr` during a frame leaves that frame's `sdi` bits unchanged and takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one readout; ignored while busy |
| cfg_wr | input | 1 | Load `cfg_din` into the configuration register |
| cfg_din | input | 13 | Configuration word for following frames |
| sck_div | input | DIV_W | Serial-clock half period minus one, in clock cycles |
| tmo_limit | input | TMO_W | Ready-wait limit in clock cycles |
| sdo | input | 1 | Data from converter (end-of-conversion, then data) |
| cs_n | output | 1 | Converter select, active low |
| sck | output | 1 | Serial clock |
| sdi | output | 1 | Data to converter |
| result | output | 24 | Conversion result, bits 28..5 of the word |
| sub_lsb | output | 5 | Sub-LSB bits 4..0 |
| sign | output | 1 | Sign bit (word bit 29) |
| ovr | output | 1 | Overrange flag |
| unr | output | 1 | Underrange flag |
| frame_err | output | 1 | Dummy bit read as 1 |
| valid | output | 1 | One-cycle strobe when a frame completes |
| timeout | output | 1 | One-cycle strobe when the ready wait expires |

## Verification
An edge counter that slips by one shifts every captured bit. The flags and result would then be wrong on the very first frame, and either `valid` would come one half-clock early or late or the frame would carry 31 or 33 pulses. A wrong half-period divider shows at once as a wrong count of high cycles on `sck`. A stale transmit register shows in the `sdi` bits that the converter model captures in the same frame. A wrong ready-wait counter moves the `timeout` strobe away from its exact expected cycle.

// File: rtl/sdadc_readout.sv
module sdadc_readout #(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16,
  parameter logic [12:0] CFG_RST = 13'h1410
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_wr,
  input  logic [12:0]      cfg_din,
  input  logic [DIV_W-1:0] sck_div,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             sdo,
  output logic             cs_n,
  output logic             sck,
  output logic             sdi,
  output logic [23:0]      result,
  output logic [4:0]       sub_lsb,
  output logic             sign,
  output logic             ovr,
  output logic             unr,
  output logic             frame_err,
  output logic             valid,
  output logic             timeout
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} st_t;
  st_t st;
  logic [12:0]      cfg, tx;
  logic [30:0]      rx;
  logic [TMO_W-1:0] cnt;
  logic [DIV_W-1:0] dc;
  logic [4:0]       nfall;

  assign sdi = (st == S_SHIFT) & tx[12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cfg <= CFG_RST; tx <= '0; rx <= '0;
      cnt <= '0; dc <= '0; nfall <= '0;
      cs_n <= 1'b1; sck <= 1'b0; valid <= 1'b0; timeout <= 1'b0;
      result <= '0; sub_lsb <= '0; sign <= 1'b0; ovr <= 1'b0; unr <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      timeout <= 1'b0;
      if (cfg_wr) cfg <= cfg_din;
      case (st)
        S_IDLE: if (start) begin
          st <= S_WAIT; cs_n <= 1'b0; cnt <= '0; tx <= cfg;
        end
        S_WAIT: begin
          if (!sdo) begin
            st <= S_SHIFT; dc <= '0; nfall <= '0;
          end else if (cnt == tmo_limit) begin
            st <= S_IDLE; cs_n <= 1'b1; timeout <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (dc == sck_div) begin
            dc <= '0;
            sck <= ~sck;
            if (!sck) begin
              rx <= {rx[29:0], sdo};
            end else begin
              tx <= {tx[11:0], 1'b0};
              nfall <= nfall + 1'b1;
              if (nfall == 5'd31) begin
                st <= S_IDLE; cs_n <= 1'b1; valid <= 1'b1;
                result <= rx[28:5];
                sub_lsb <= rx[4:0];
                sign <= rx[29];
                ovr <= rx[29] & rx[28];
                unr <= ~rx[29] & ~rx[28];
                frame_err <= rx[30];
              end
            end
          end else begin
            dc <= dc + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sdadc_readout_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic sdi,
  input logic sign,
  input logic ovr,
  input logic unr,
  input logic valid,
  input logic timeout
);
  AST_SCK_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);                 // R4
  AST_SCK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> !cs_n);          // R2
  AST_SDI_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(sdi)); // R6
  AST_VALID_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);              // R9
  AST_VALID_RELEASE:assert property (@(posedge clk) disable iff (!rst_n) valid |-> (cs_n && !sck));      // R9
  AST_TMO_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) timeout |-> (cs_n && !valid));  // R3
  AST_OVR_SIGN:     assert property (@(posedge clk) disable iff (!rst_n) ovr |-> (sign && !unr));        // R7
  AST_UNR_SIGN:     assert property (@(posedge clk) disable iff (!rst_n) unr |-> !sign);                 // R7
endmodule

bind sdadc_readout sdadc_readout_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
  .sign(sign), .ovr(ovr), .unr(unr), .valid(valid), .timeout(timeout)
);

// File: tb/sdadc_readout_tb.sv
module sdadc_readout_tb_top;
  logic clk = 0, rst_n = 0, start = 0, cfg_wr = 0;
  logic [12:0] cfg_din = '0;
  logic [7:0]  sck_div = 8'd1;
  logic [15:0] tmo_limit = 16'd1000;
  logic sdo, cs_n, sck, sdi, sign, ovr, unr, frame_err, valid, timeout;
  logic [23:0] result;
  logic [4:0]  sub_lsb;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sdadc_readout dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
    .sck_div(sck_div), .tmo_limit(tmo_limit), .sdo(sdo), .cs_n(cs_n), .sck(sck),
    .sdi(sdi), .result(result), .sub_lsb(sub_lsb), .sign(sign), .ovr(ovr),
    .unr(unr), .frame_err(frame_err), .valid(valid), .timeout(timeout)
  );

  // converter serial-side model
  logic [31:0] mw = '0;
  logic ready = 0;
  int fcnt = 0;
  logic [31:0] cap = '0;
  always @(negedge sck or posedge cs_n) if (cs_n) fcnt <= 0; else fcnt <= fcnt + 1;
  always @(posedge sck) cap <= {cap[30:0], sdi};
  assign sdo = cs_n ? 1'b1 : (fcnt == 0 ? ~ready : (fcnt >= 32 ? 1'b1 : mw[5'(31 - fcnt)]));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [31:0] WORDS [NV] = '{32'h2ABCDEF3, 32'h1234567A, 32'h3FFFFFE0,
                                         32'h0000001F, 32'h6ABC1234, 32'h1FFFFFFF};
  localparam logic [12:0] CFGS [NV] = '{13'h1410, 13'h17FF, 13'h1555, 13'h1000, 13'h1234, 13'h16AB};
  localparam logic [7:0]  DIVS [NV] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd0, 8'd5};
  localparam int          DLYS [NV] = '{1, 4, 30, 2, 9, 1};
  // expected {frame_err, sign, ovr, unr}
  localparam logic [3:0]  EXPF [NV] = '{4'b0100, 4'b0000, 4'b0110, 4'b0001, 4'b1100, 4'b0000};

  task automatic run_frame(input logic [31:0] w, input logic [12:0] cexp, input logic [7:0] div,
                           input int dly, input bit inj, input logic [12:0] alt);
    int cyc = 0, hic = 0, rises = 0;
    bit early = 0, got = 0;
    logic psck = 0;
    mw = w; sck_div = div; ready = 0;
    @(negedge clk) start = 1;
    while (cyc < 3000 && !got) begin
      @(negedge clk);
      cyc++;
      if (inj && cyc == dly + 20) begin start = 1; cfg_wr = 1; cfg_din = alt; end
      else begin start = 0; cfg_wr = 0; end
      if (cyc == dly) ready = 1;
      if (sck && !ready) early = 1;
      if (sck) hic++;
      if (sck && !psck) rises++;
      psck = sck;
      if (valid) got = 1;
    end
    ready = 0;
    check(got, "R9 valid seen", 64'(got), 64'd1);
    check(cs_n, "R9 cs_n released", 64'(cs_n), 64'd1);
    check(!early, "R2 no sck before ready", 64'(early), 64'd0);
    check(rises == 32, "R4 pulse count", 64'(rises), 64'd32);
    check(hic == 32 * (div + 1), "R4 high width", 64'(hic), 64'(32 * (div + 1)));
    check(result == w[28:5], "R5 result", 64'(result), 64'(w[28:5]));
    check(sub_lsb == w[4:0], "R5 sub_lsb", 64'(sub_lsb), 64'(w[4:0]));
    check(sign == w[29], "R7 sign", 64'(sign), 64'(w[29]));
    check(ovr == (w[29] & w[28]), "R7 ovr", 64'(ovr), 64'(w[29] & w[28]));
    check(unr == ~(w[29] | w[28]), "R7 unr", 64'(unr), 64'(~(w[29] | w[28])));
    check(frame_err == w[30], "R8 frame_err", 64'(frame_err), 64'(w[30]));
    check(cap == {cexp, 19'b0}, "R6 sdi word", 64'(cap), 64'({cexp, 19'b0}));
    @(negedge clk);
    check(!valid, "R9 valid one cycle", 64'(valid), 64'd0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({cs_n, sck, sdi, valid, timeout} == 5'b10000, "R1 reset outputs",
          64'({cs_n, sck, sdi, valid, timeout}), 64'b10000);
    rst_n = 1;
    @(negedge clk);
    check({cs_n, sck} == 2'b10, "R1 idle after reset", 64'({cs_n, sck}), 64'b10);
    // R1: default configuration goes out on the first frame
    run_frame(32'h2000_0000, 13'h1410, 8'd1, 3, 0, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) begin cfg_wr = 1; cfg_din = CFGS[i]; end
      @(negedge clk) cfg_wr = 0;
      run_frame(WORDS[i], CFGS[i], DIVS[i], DLYS[i], 0, '0);
      check({frame_err, sign, ovr, unr} == EXPF[i], "R7 R8 table flags",
            64'({frame_err, sign, ovr, unr}), 64'(EXPF[i]));
    end

    // R3: timeout with sdo held high
    begin
      int k = 0;
      bit seen = 0, vseen = 0;
      tmo_limit = 16'd20; ready = 0;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      while (k < 100 && !seen) begin
        @(negedge clk);
        k++;
        if (valid) vseen = 1;
        if (timeout) seen = 1;
      end
      check(seen && k == 21, "R3 timeout cycle", 64'(k), 64'd21);
      check(cs_n, "R3 cs_n released", 64'(cs_n), 64'd1);
      @(negedge clk);
      check(!timeout && !vseen && !valid, "R3 single pulse no valid", 64'({timeout, vseen, valid}), 64'd0);
      tmo_limit = 16'd1000;
    end

    // R10: start and cfg_wr during a frame
    @(negedge clk) begin cfg_wr = 1; cfg_din = 13'h1111; end
    @(negedge clk) cfg_wr = 0;
    run_frame(32'h2123_4560, 13'h1111, 8'd1, 2, 1, 13'h1ACE);
    begin
      bit moved = 0;
      repeat (10) begin @(negedge clk); if (!cs_n) moved = 1; end
      check(!moved, "R10 start ignored while busy", 64'(moved), 64'd0);
    end
    run_frame(32'h1000_0000, 13'h1ACE, 8'd0, 1, 0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule